// File: doc/BRIEF.md
# SPD Bank and Protection Controller

This block is the command layer of a serial presence-detect memory slave. It sits behind a two-wire byte engine. That engine reports bus START and STOP events, each completed received byte, and the level of the write-protect pin. The block sorts the first byte of each transfer into a memory access or a utility command, and it tracks the byte-address and data phases that follow. It holds the register for the active 256-byte bank and four write-protect flags, one for each 128-byte block.

The block answers the host only through the acknowledge bit. After every received byte it sets `ack_o` for the acknowledge slot that follows. A protection-status query or a bank query returns its answer through that ACK/NoACK choice; no data is driven. At STOP the block asks for a write cycle when the transfer was accepted. `wr_mem_o` tells a memory write apart from a protection update. A protection update takes effect when the external write timer reports completion.

Top module: `spd_ctl`

## Requirements
- R1: After reset `ack_o` is 0, `bank_o` is 0 and no flag is set, so all four status queries and the bank query get ACK.
- R2: A first byte with upper nibble 1010 is a memory command (bit 0 = 1 read, 0 write). It gets ACK only when bits 3..1 equal `pins_i[2:0]`. A first byte with any upper nibble other than 1010 or 0110 gets NoACK.
- R3: With upper nibble 0110, bits 3..0 decode as follows: protect block 0/1/2/3 = 0010/1000/1010/0000, clear all = 0110, query block 0/1/2/3 = 0011/1001/1011/0001, bank 0 = 1100, bank 1 = 1110, bank query = 1101. The codes 0100, 0101, 0111 and 1111 get NoACK.
- R4: While `busy_i` is high, the first byte of a transfer gets NoACK.
- R5: A status query gets ACK when its block is unprotected and NoACK when it is protected. The bank query gets ACK for bank 0 and NoACK for bank 1.
- R6: A bank-select command gets ACK on its first byte and on the dummy address byte, and NoACK on the dummy data byte. `bank_o` takes the new value two cycles after that data byte, and STOP does not request a write.
- R7: A protect command whose block is clear gets ACK on all three bytes when `hv_i` is high at the first byte and at the data byte. At STOP it gives a one-cycle `wr_req_o` with `wr_mem_o` = 0, and the flag is set at `wr_done_i`. If `hv_i` is low at either point, the data byte gets NoACK and no write is requested.
- R8: A protect command aimed at a block that is already protected gets NoACK on its first byte and requests no write.
- R9: Clear-all follows the same accept rules as R7, and it clears all four flags at `wr_done_i`.
- R10: In a memory write, the byte address together with `bank_o` selects block {bank, address bit 7}. A data byte to an unprotected block gets ACK, and STOP then gives `wr_req_o` with `wr_mem_o` = 1. If the block is protected, the data byte gets NoACK and no write follows.
- R11: If `wp_i` is high when the byte-address byte completes, the memory data bytes get NoACK and no write is requested.
- R12: START and STOP drive `ack_o` to 0. Bytes received after a read command or after a rejected first byte get NoACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_i | input | 1 | STOP seen (one-cycle pulse) |
| byte_vld_i | input | 1 | Received byte complete (one-cycle pulse) |
| byte_i | input | 8 | Received byte |
| pins_i | input | 3 | Logic levels of the three address pins |
| hv_i | input | 1 | High-voltage detect on address pin 0 |
| wp_i | input | 1 | Hardware write-protect pin level |
| busy_i | input | 1 | Internal write cycle in progress |
| wr_done_i | input | 1 | Write cycle finished (one-cycle pulse) |
| ack_o | output | 1 | 1 = drive ACK in the next acknowledge slot |
| wr_req_o | output | 1 | Start a write cycle (one-cycle pulse) |
| wr_mem_o | output | 1 | With wr_req_o: 1 = memory write, 0 = protection update |
| bank_o | output | 1 | Active bank |

## Verification
The acknowledge decision is driven with five kinds of first byte:
- memory bytes whose select bits match or mismatch the pins;
- foreign upper nibbles;
- every reserved utility code;
- each protect and query code;
- first bytes sent while busy.

Together these separate the preamble decode from the pin compare and from the busy gate. Three-byte sequences run with high voltage present, absent, and on a block that is already protected. These show that each refusal lands on the correct byte. Memory writes are aimed at blocks in each bank, before and after protection and bank switches. This proves that the bank bit enters the block index, and a write with the pin high tells the hardware refusal apart from the flag refusal.

// File: rtl/spd_ctl_pkg.sv
package spd_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam int PIN_W  = 3;
  localparam int NBLK   = 4;
  localparam int BLK_W  = $clog2(NBLK);
  localparam logic [3:0] PRE_MEM  = 4'b1010;
  localparam logic [3:0] PRE_UTIL = 4'b0110;

  typedef enum logic [2:0] {
    K_NONE, K_MEM_WR, K_MEM_RD, K_SET_PROT, K_CLR_PROT, K_RD_PROT, K_SET_BANK, K_RD_BANK
  } cmd_e;

  typedef enum logic [1:0] {S_IDLE, S_SADDR, S_WADDR, S_DATA} sess_e;
endpackage

// File: rtl/spd_slave_dec.sv
module spd_slave_dec
  import spd_ctl_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [PIN_W-1:0]  pins_i,
  output cmd_e              cmd_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic              bank_sel_o
);
  logic rd;
  assign rd = byte_i[0];

  always_comb begin
    cmd_o      = K_NONE;
    blk_o      = '0;
    bank_sel_o = byte_i[1];
    if (byte_i[7:4] == PRE_MEM) begin
      if (byte_i[3:1] == pins_i) cmd_o = rd ? K_MEM_RD : K_MEM_WR;
    end else if (byte_i[7:4] == PRE_UTIL) begin
      case (byte_i[3:1])
        3'b001:  begin blk_o = BLK_W'(0); cmd_o = rd ? K_RD_PROT : K_SET_PROT; end
        3'b100:  begin blk_o = BLK_W'(1); cmd_o = rd ? K_RD_PROT : K_SET_PROT; end
        3'b101:  begin blk_o = BLK_W'(2); cmd_o = rd ? K_RD_PROT : K_SET_PROT; end
        3'b000:  begin blk_o = BLK_W'(3); cmd_o = rd ? K_RD_PROT : K_SET_PROT; end
        3'b011:  cmd_o = rd ? K_NONE : K_CLR_PROT;
        3'b110:  cmd_o = rd ? K_RD_BANK : K_SET_BANK;
        3'b111:  cmd_o = rd ? K_NONE : K_SET_BANK;
        default: cmd_o = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/spd_prot_regs.sv
module spd_prot_regs
  import spd_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bank_wr_i,
  input  logic             bank_val_i,
  input  logic             arm_i,
  input  logic             arm_clr_i,
  input  logic [BLK_W-1:0] arm_blk_i,
  input  logic             done_i,
  output logic             bank_o,
  output logic [NBLK-1:0]  prot_o
);
  logic             bank_q, pend_q, pend_clr_q;
  logic [BLK_W-1:0] pend_blk_q;
  logic [NBLK-1:0]  prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_clr_q <= 1'b0;
      pend_blk_q <= '0;
    end else begin
      if (bank_wr_i) bank_q <= bank_val_i;
      if (arm_i) begin
        pend_q     <= 1'b1;
        pend_clr_q <= arm_clr_i;
        pend_blk_q <= arm_blk_i;
      end else if (done_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  // flags only change when the write timer reports completion
  for (genvar g = 0; g < NBLK; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prot_q[g] <= 1'b0;
      else if (done_i && pend_q) begin
        if (pend_clr_q) prot_q[g] <= 1'b0;
        else if (pend_blk_q == BLK_W'(g)) prot_q[g] <= 1'b1;
      end
    end
  end

  assign bank_o = bank_q;
  assign prot_o = prot_q;
endmodule

// File: rtl/spd_session.sv
module spd_session
  import spd_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic             amsb_i,
  input  cmd_e             cmd_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             bank_sel_i,
  input  logic             hv_i,
  input  logic             wp_i,
  input  logic             busy_i,
  input  logic             bank_i,
  input  logic [NBLK-1:0]  prot_i,
  output logic             ack_o,
  output logic             wr_req_o,
  output logic             wr_mem_o,
  output logic             bank_wr_o,
  output logic             bank_val_o,
  output logic             prot_arm_o,
  output logic             prot_clr_o,
  output logic [BLK_W-1:0] prot_blk_o
);
  sess_e            st_q;
  cmd_e             cmd_q;
  logic [BLK_W-1:0] blk_q;
  logic             bank_val_q, hv_q, wp_q, amsb_q, arm_q, refused_q;
  logic             ack_q, wr_req_q, wr_mem_q, bank_wr_q;
  logic             mem_ok, hv_ok;

  assign mem_ok = !refused_q && !wp_q && !prot_i[{bank_i, amsb_q}];
  assign hv_ok  = hv_q && hv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  cmd_q <= K_NONE;  blk_q <= '0;
      bank_val_q <= 1'b0;  hv_q <= 1'b0;  wp_q <= 1'b0;  amsb_q <= 1'b0;
      arm_q <= 1'b0;  refused_q <= 1'b0;  ack_q <= 1'b0;
      wr_req_q <= 1'b0;  wr_mem_q <= 1'b0;  bank_wr_q <= 1'b0;
    end else begin
      wr_req_q  <= 1'b0;
      bank_wr_q <= 1'b0;
      if (start_i) begin
        st_q <= S_SADDR;  ack_q <= 1'b0;  arm_q <= 1'b0;  refused_q <= 1'b0;
      end else if (stop_i) begin
        st_q  <= S_IDLE;
        ack_q <= 1'b0;
        arm_q <= 1'b0;
        if (arm_q) begin
          wr_req_q <= 1'b1;
          wr_mem_q <= (cmd_q == K_MEM_WR);
        end
      end else if (byte_vld_i) begin
        ack_q <= 1'b0;
        case (st_q)
          S_SADDR: begin
            cmd_q <= cmd_i;  blk_q <= blk_i;  bank_val_q <= bank_sel_i;  hv_q <= hv_i;
            st_q  <= S_IDLE;
            if (!busy_i) begin
              case (cmd_i)
                K_MEM_WR, K_CLR_PROT, K_SET_BANK: begin ack_q <= 1'b1; st_q <= S_WADDR; end
                K_SET_PROT: if (!prot_i[blk_i]) begin ack_q <= 1'b1; st_q <= S_WADDR; end
                K_MEM_RD:   ack_q <= 1'b1;
                K_RD_PROT:  ack_q <= !prot_i[blk_i];
                K_RD_BANK:  ack_q <= !bank_i;
                default:    ack_q <= 1'b0;
              endcase
            end
          end
          S_WADDR: begin
            ack_q  <= 1'b1;
            amsb_q <= amsb_i;
            wp_q   <= wp_i;
            st_q   <= S_DATA;
          end
          S_DATA: begin
            case (cmd_q)
              K_MEM_WR: begin
                if (mem_ok) begin ack_q <= 1'b1; arm_q <= 1'b1; end
                else begin refused_q <= 1'b1; arm_q <= 1'b0; end
              end
              K_SET_PROT, K_CLR_PROT: begin
                ack_q <= hv_ok;  arm_q <= hv_ok;  st_q <= S_IDLE;
              end
              K_SET_BANK: begin bank_wr_q <= 1'b1; st_q <= S_IDLE; end
              default:    st_q <= S_IDLE;
            endcase
          end
          default: ack_q <= 1'b0;
        endcase
      end
    end
  end

  assign ack_o      = ack_q;
  assign wr_req_o   = wr_req_q;
  assign wr_mem_o   = wr_mem_q;
  assign bank_wr_o  = bank_wr_q;
  assign bank_val_o = bank_val_q;
  assign prot_arm_o = wr_req_q && !wr_mem_q;
  assign prot_clr_o = (cmd_q == K_CLR_PROT);
  assign prot_blk_o = blk_q;
endmodule

// File: rtl/spd_ctl.sv
module spd_ctl
  import spd_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic              hv_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic              wr_done_i,
  output logic              ack_o,
  output logic              wr_req_o,
  output logic              wr_mem_o,
  output logic              bank_o
);
  cmd_e             dec_cmd;
  logic [BLK_W-1:0] dec_blk, arm_blk;
  logic             dec_bank, bank_wr, bank_val, arm, arm_clr;
  logic [NBLK-1:0]  prot;

  spd_slave_dec u_dec (
    .byte_i(byte_i), .pins_i(pins_i),
    .cmd_o(dec_cmd), .blk_o(dec_blk), .bank_sel_o(dec_bank)
  );

  spd_session u_sess (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_i), .stop_i(stop_i), .byte_vld_i(byte_vld_i),
    .amsb_i(byte_i[BYTE_W-1]),
    .cmd_i(dec_cmd), .blk_i(dec_blk), .bank_sel_i(dec_bank),
    .hv_i(hv_i), .wp_i(wp_i), .busy_i(busy_i),
    .bank_i(bank_o), .prot_i(prot),
    .ack_o(ack_o), .wr_req_o(wr_req_o), .wr_mem_o(wr_mem_o),
    .bank_wr_o(bank_wr), .bank_val_o(bank_val),
    .prot_arm_o(arm), .prot_clr_o(arm_clr), .prot_blk_o(arm_blk)
  );

  spd_prot_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bank_wr_i(bank_wr), .bank_val_i(bank_val),
    .arm_i(arm), .arm_clr_i(arm_clr), .arm_blk_i(arm_blk),
    .done_i(wr_done_i),
    .bank_o(bank_o), .prot_o(prot)
  );
endmodule

// File: rtl/spd_ctl_chk.sv
module spd_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       byte_vld_i,
  input logic [3:0] pre_i,
  input logic       busy_i,
  input logic       ack_o,
  input logic       wr_req_o,
  input logic       bank_o
);
  logic first_q;  // next byte is the first byte of a transfer

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) first_q <= 1'b0;
    else if (start_i) first_q <= 1'b1;
    else if (byte_vld_i || stop_i) first_q <= 1'b0;
  end

  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q && byte_vld_i && !start_i && !stop_i && busy_i) |=> !ack_o); // R4
  AST_BAD_PRE_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q && byte_vld_i && !start_i && !stop_i && pre_i != 4'b1010 && pre_i != 4'b0110)
      |=> !ack_o); // R2
  AST_WR_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> $past(stop_i)); // R10
  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> !wr_req_o); // R7
  AST_BANK_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_o) |-> $past(byte_vld_i, 2)); // R6
  AST_EVENT_CLEARS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !ack_o); // R12
endmodule

bind spd_ctl spd_ctl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .byte_vld_i(byte_vld_i), .pre_i(byte_i[7:4]), .busy_i(busy_i),
  .ack_o(ack_o), .wr_req_o(wr_req_o), .bank_o(bank_o)
);

// File: tb/spd_ctl_tb.sv
module spd_ctl_tb_top;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       start_i = 0, stop_i = 0, byte_vld_i = 0, hv_i = 0, wp_i = 0, busy_i = 0, wr_done_i = 0;
  logic [7:0] byte_i = '0;
  logic [2:0] pins_i = 3'b101;
  logic       ack_o, wr_req_o, wr_mem_o, bank_o;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  spd_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .pins_i(pins_i), .hv_i(hv_i),
    .wp_i(wp_i), .busy_i(busy_i), .wr_done_i(wr_done_i),
    .ack_o(ack_o), .wr_req_o(wr_req_o), .wr_mem_o(wr_mem_o), .bank_o(bank_o)
  );

  localparam logic [7:0] MWR = 8'hAA, MRD = 8'hAB;
  localparam logic [7:0] RPS0 = 8'h63, RPS1 = 8'h69, RPS2 = 8'h6B, RPS3 = 8'h61, RPA = 8'h6D;
  localparam logic [7:0] SWP1 = 8'h68, SWP3 = 8'h60, CWP = 8'h66, SPA0 = 8'h6C, SPA1 = 8'h6E;

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic bus_byte(input logic [7:0] b, input int exp_ack, input string req);
    @(negedge clk); byte_i = b; byte_vld_i = 1;
    @(negedge clk); byte_vld_i = 0;
    chk(ack_o, exp_ack, req);
  endtask

  task automatic bus_stop(input int exp_wr, input int exp_mem, input string req);
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    chk(wr_req_o, exp_wr, req);
    if (exp_wr == 1) chk(wr_mem_o, exp_mem, req);
    chk(ack_o, 0, "R12 ack after stop");
  endtask

  task automatic wcycle();
    busy_i = 1;
    repeat (3) @(negedge clk);
    wr_done_i = 1;
    @(negedge clk); wr_done_i = 0; busy_i = 0;
  endtask

  task automatic query(input logic [7:0] b, input int exp, input string req);
    bus_start(); bus_byte(b, exp, req); bus_stop(0, 0, req);
  endtask

  task automatic mem_write(input logic [7:0] a, input int exp_data, input string req);
    bus_start(); bus_byte(MWR, 1, req); bus_byte(a, 1, req);
    bus_byte(8'h5A, exp_data, req); bus_byte(8'hA5, exp_data, req);
    bus_stop(exp_data, 1, req);
    if (exp_data == 1) wcycle();
  endtask

  task automatic t_reset();
    chk(ack_o, 0, "R1 ack"); chk(bank_o, 0, "R1 bank"); chk(wr_req_o, 0, "R1 wr_req");
    query(RPS0, 1, "R1 rps0"); query(RPS1, 1, "R1 rps1");
    query(RPS2, 1, "R1 rps2"); query(RPS3, 1, "R1 rps3");
    query(RPA, 1, "R1 rpa");
  endtask

  task automatic t_addr();
    bus_start(); bus_byte(MRD, 1, "R2 match"); bus_byte(8'h00, 0, "R12 byte after read"); bus_stop(0, 0, "R2");
    query(8'hA9, 0, "R2 pin mismatch");
    query(8'hBB, 0, "R2 foreign preamble");
    bus_start(); bus_byte(8'h1A, 0, "R2 foreign preamble"); bus_byte(8'h00, 0, "R12 after nack"); bus_stop(0, 0, "R12");
  endtask

  task automatic t_reserved();
    query(8'h64, 0, "R3 reserved 0100"); query(8'h65, 0, "R3 reserved 0101");
    query(8'h67, 0, "R3 reserved 0111"); query(8'h6F, 0, "R3 reserved 1111");
  endtask

  task automatic t_busy();
    mem_write(8'h10, 1, "R10 plain write");
    busy_i = 1;
    query(MWR, 0, "R4 busy mem"); query(RPS0, 0, "R4 busy rps");
    busy_i = 0;
    query(MWR, 1, "R4 idle again");
  endtask

  task automatic t_protect();
    hv_i = 0;
    bus_start(); bus_byte(SWP1, 1, "R7 nohv addr"); bus_byte(8'h00, 1, "R7 nohv dummy");
    bus_byte(8'h00, 0, "R7 nohv data"); bus_stop(0, 0, "R7 nohv no write");
    query(RPS1, 1, "R7 flag still clear");
    hv_i = 1;
    bus_start(); bus_byte(SWP1, 1, "R7 addr"); bus_byte(8'h00, 1, "R7 dummy");
    bus_byte(8'h00, 1, "R7 data"); bus_stop(1, 0, "R7 wr req");
    query(RPS1, 1, "R7 not before done");
    wcycle();
    hv_i = 0;
    query(RPS1, 0, "R5 rps1 set"); query(RPS0, 1, "R5 rps0 clear");
    hv_i = 1;
    bus_start(); bus_byte(SWP1, 0, "R8 already set"); bus_stop(0, 0, "R8 no write");
    hv_i = 0;
  endtask

  task automatic t_mem_prot();
    mem_write(8'h85, 0, "R10 protected block1");
    mem_write(8'h05, 1, "R10 open block0");
    wp_i = 1;
    mem_write(8'h05, 0, "R11 wp high");
    wp_i = 0;
  endtask

  task automatic t_bank();
    bus_start(); bus_byte(SPA1, 1, "R6 addr"); bus_byte(8'h00, 1, "R6 dummy");
    bus_byte(8'h00, 0, "R6 data nack");
    @(negedge clk); chk(bank_o, 1, "R6 bank1");
    bus_stop(0, 0, "R6 no write");
    query(RPA, 0, "R5 rpa bank1");
    mem_write(8'h85, 1, "R10 bank1 block3 open");
    hv_i = 1;
    bus_start(); bus_byte(SWP3, 1, "R7 swp3"); bus_byte(8'h00, 1, "R7 swp3");
    bus_byte(8'h00, 1, "R7 swp3"); bus_stop(1, 0, "R7 swp3"); wcycle();
    hv_i = 0;
    mem_write(8'h85, 0, "R10 bank1 block3 protected");
    mem_write(8'h05, 1, "R10 bank1 block2 open");
    bus_start(); bus_byte(SPA0, 1, "R6 sel0"); bus_byte(8'h00, 1, "R6 sel0");
    bus_byte(8'h00, 0, "R6 sel0"); @(negedge clk); chk(bank_o, 0, "R6 bank0");
    bus_stop(0, 0, "R6");
    query(RPA, 1, "R5 rpa bank0");
  endtask

  task automatic t_clear();
    bus_start(); bus_byte(CWP, 1, "R9 nohv"); bus_byte(8'h00, 1, "R9 nohv");
    bus_byte(8'h00, 0, "R9 nohv data"); bus_stop(0, 0, "R9 nohv");
    query(RPS3, 0, "R9 still set");
    hv_i = 1;
    bus_start(); bus_byte(CWP, 1, "R9 addr"); bus_byte(8'h00, 1, "R9 dummy");
    bus_byte(8'h00, 1, "R9 data"); bus_stop(1, 0, "R9 wr"); wcycle();
    hv_i = 0;
    query(RPS1, 1, "R9 rps1 clear"); query(RPS3, 1, "R9 rps3 clear");
    mem_write(8'h85, 1, "R9 block1 writable");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_reserved();
    t_busy();
    t_protect();
    t_mem_prot();
    t_bank();
    t_clear();
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      summary();
      $finish;
    end
  end
endmodule